// File: doc/BRIEF.md
# Interrupt Coalescing Counter and Delay Timer

This block moderates the completion interrupts of one transfer channel. Instead of interrupting on every finished frame, it counts frame completions down from a programmable threshold and emits a one-cycle completion-interrupt set pulse only when the count runs out. The count then reloads from the threshold. A second mechanism catches a trickle of traffic that never reaches the threshold. A delay timer is rearmed on every completion. When it runs down to zero it emits a one-cycle delay-interrupt set pulse and reloads the count.

Both settings come from the channel's 32-bit control register value. The threshold sits in bits 23:16 and the delay in bits 31:24. The live count and the remaining timer value are driven out so that status logic can return them in its own bits 23:16 and 31:24. The timer advances only on cycles where the tick enable is high. That enable comes from a prescaler on the core clock outside this block. Storing, masking and clearing the interrupt flags is done by the surrounding register logic.

Top module: `irq_moderator`

## Requirements
- R1: After the asynchronous reset, the live count is 1, the timer is 0, and both set pulses are low.
- R2: A frame completion while the count is above 1 lowers the count by exactly one in the next cycle, provided neither a control write nor a timer expiry falls in the same cycle.
- R3: A frame completion while the count is 1 or 0 raises the completion set pulse for one cycle in the next cycle. The count reloads from control bits 23:16.
- R4: A frame completion while control bits 31:24 are non-zero loads the timer with that value, replacing whatever the timer held.
- R5: A frame completion while control bits 31:24 are zero leaves the timer value untouched.
- R6: The timer drops by one on each cycle with the tick enable high and a non-zero value. It holds on every other cycle and stays at zero once there.
- R7: A tick that takes the timer from 1 to 0 raises the delay set pulse for exactly one cycle and reloads the count from bits 23:16. Further ticks at zero raise no pulse.
- R8: A control write reloads the count from bits 23:16 of the presented value. It overrides a completion in the same cycle, and that completion raises no completion pulse.
- R9: A completion with a non-zero delay in the same cycle as a 1-to-0 tick restarts the timer with the delay. No delay pulse is raised.
- R10: A completion with a zero delay in the same cycle as a 1-to-0 tick lets the expiry happen. The delay pulse fires and the count ends at the threshold, reloaded only once.
- R11: A soft reset pulse sets the count to 1 and the timer to 0, and suppresses both set pulses. It overrides every other input in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrlValue | input | 32 | Current control register contents (threshold 23:16, delay 31:24) |
| ctrlWr | input | 1 | High for one cycle when software writes the control register |
| frameDone | input | 1 | One-cycle pulse per completed frame |
| softRst | input | 1 | One-cycle channel soft reset |
| tickEn | input | 1 | Timer advance enable from the prescaler |
| cmplSet | output | 1 | One-cycle completion-interrupt set pulse |
| delaySet | output | 1 | One-cycle delay-interrupt set pulse |
| liveCount | output | 8 | Remaining completions before the next completion pulse |
| liveTimer | output | 8 | Remaining delay ticks, 0 when stopped |

## Verification
Directed sequences walk the count through several thresholds to a pulse. They arm the timer with both zero and non-zero delays, so a restart can be told apart from a timer that runs on untouched. The runs then pile up coincident events: a control write on top of a completion, and a completion on top of a 1-to-0 tick with each delay setting. These cases separate the priority orderings, which otherwise give identical outputs. A long seeded random phase mixes completions, ticks, occasional writes with varied fields and rare soft resets. It compares every cycle against a bench model, including threshold 0 and delays of 1.

// File: rtl/irq_mod_pkg.sv
package irq_mod_pkg;
  // Strobes from the decision logic to the counter/timer datapath
  typedef struct packed {
    logic cntInit;    // force count to the reset value
    logic cntReload;  // load count from threshold field
    logic cntDec;     // count minus one
    logic tmrClear;   // stop timer at zero
    logic tmrLoad;    // rearm timer from delay field
    logic tmrDec;     // timer minus one
    logic fireCmpl;   // completion set pulse next cycle
    logic fireDly;    // delay set pulse next cycle
  } modStrobes_t;
endpackage

// File: rtl/irq_mod_ctrl.sv
module irq_mod_ctrl
  import irq_mod_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int TMR_W = 8
) (
  input  logic             ctrlWr,
  input  logic             frameDone,
  input  logic             softRst,
  input  logic             tickEn,
  input  logic [TMR_W-1:0] dlyField,
  input  logic [CNT_W-1:0] curCount,
  input  logic [TMR_W-1:0] curTimer,
  output modStrobes_t      strb
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [TMR_W-1:0] TMR_ONE = TMR_W'(1);

  logic restart, expire, thrHit, tmrIdle;

  always_comb begin
    tmrIdle = (curTimer == '0);
    restart = frameDone && (dlyField != '0);
    expire  = tickEn && (curTimer == TMR_ONE) && !restart;
    thrHit  = frameDone && (curCount <= CNT_ONE);
    strb    = '0;
    if (softRst) begin
      strb.cntInit  = 1'b1;
      strb.tmrClear = 1'b1;
    end else begin
      strb.cntReload = ctrlWr || expire || thrHit;
      strb.cntDec    = frameDone && !(ctrlWr || expire || thrHit);
      strb.tmrLoad   = restart;
      strb.tmrDec    = tickEn && !tmrIdle && !restart;
      strb.fireCmpl  = thrHit && !ctrlWr;
      strb.fireDly   = expire;
    end
  end
endmodule

// File: rtl/irq_mod_dpath.sv
module irq_mod_dpath
  import irq_mod_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  modStrobes_t      strb,
  input  logic [CNT_W-1:0] thrField,
  input  logic [TMR_W-1:0] dlyField,
  output logic [CNT_W-1:0] curCount,
  output logic [TMR_W-1:0] curTimer,
  output logic             cmplSet,
  output logic             delaySet
);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curCount <= CNT_INIT;
    end else if (strb.cntInit) begin
      curCount <= CNT_INIT;
    end else if (strb.cntReload) begin
      curCount <= thrField;
    end else if (strb.cntDec) begin
      curCount <= curCount - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curTimer <= '0;
    end else if (strb.tmrClear) begin
      curTimer <= '0;
    end else if (strb.tmrLoad) begin
      curTimer <= dlyField;
    end else if (strb.tmrDec) begin
      curTimer <= curTimer - TMR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmplSet  <= 1'b0;
      delaySet <= 1'b0;
    end else begin
      cmplSet  <= strb.fireCmpl;
      delaySet <= strb.fireDly;
    end
  end
endmodule

// File: rtl/irq_moderator.sv
module irq_moderator
  import irq_mod_pkg::*;
#(
  parameter int CTRL_W  = 32,
  parameter int CNT_W   = 8,
  parameter int TMR_W   = 8,
  parameter int THR_LSB = 16,
  parameter int DLY_LSB = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrlValue,
  input  logic              ctrlWr,
  input  logic              frameDone,
  input  logic              softRst,
  input  logic              tickEn,
  output logic              cmplSet,
  output logic              delaySet,
  output logic [CNT_W-1:0]  liveCount,
  output logic [TMR_W-1:0]  liveTimer
);
  logic [CNT_W-1:0] thrField;
  logic [TMR_W-1:0] dlyField;
  logic             unusedCtrlBits;
  modStrobes_t      strb;

  assign thrField       = ctrlValue[THR_LSB +: CNT_W];
  assign dlyField       = ctrlValue[DLY_LSB +: TMR_W];
  assign unusedCtrlBits = ^ctrlValue[THR_LSB-1:0];

  irq_mod_ctrl #(.CNT_W(CNT_W), .TMR_W(TMR_W)) ctrl_i (
    .ctrlWr    (ctrlWr),
    .frameDone (frameDone),
    .softRst   (softRst),
    .tickEn    (tickEn),
    .dlyField  (dlyField),
    .curCount  (liveCount),
    .curTimer  (liveTimer),
    .strb      (strb)
  );

  irq_mod_dpath #(.CNT_W(CNT_W), .TMR_W(TMR_W)) dpath_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .thrField (thrField),
    .dlyField (dlyField),
    .curCount (liveCount),
    .curTimer (liveTimer),
    .cmplSet  (cmplSet),
    .delaySet (delaySet)
  );
endmodule

// File: rtl/irq_moderator_chk.sv
module irq_moderator_chk #(
  parameter int CTRL_W  = 32,
  parameter int CNT_W   = 8,
  parameter int TMR_W   = 8,
  parameter int DLY_LSB = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CTRL_W-1:0] ctrlValue,
  input logic              frameDone,
  input logic              softRst,
  input logic              tickEn,
  input logic              cmplSet,
  input logic              delaySet,
  input logic [CNT_W-1:0]  liveCount,
  input logic [TMR_W-1:0]  liveTimer
);
  // R3
  cmpl_needs_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmplSet |-> $past(frameDone));

  // R7
  dly_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    delaySet |-> ($past(tickEn) && liveTimer == '0));

  // R6
  timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tickEn && !frameDone && !softRst) |=> $stable(liveTimer));

  // R9
  rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frameDone && !softRst && ctrlValue[DLY_LSB +: TMR_W] != '0)
      |=> (liveTimer == $past(ctrlValue[DLY_LSB +: TMR_W]) && !delaySet));

  // R11
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    softRst |=> (liveCount == CNT_W'(1) && liveTimer == '0 && !cmplSet && !delaySet));
endmodule

bind irq_moderator irq_moderator_chk #(
  .CTRL_W(CTRL_W), .CNT_W(CNT_W), .TMR_W(TMR_W), .DLY_LSB(DLY_LSB)
) chk_i (
  .clk(clk), .rst_n(rst_n), .ctrlValue(ctrlValue), .frameDone(frameDone),
  .softRst(softRst), .tickEn(tickEn), .cmplSet(cmplSet), .delaySet(delaySet),
  .liveCount(liveCount), .liveTimer(liveTimer)
);

// File: tb/irq_moderator_tb.sv
`timescale 1ns/1ps
module irq_moderator_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ctrlValue = 32'h0001_0000;
  logic        ctrlWr = 1'b0, frameDone = 1'b0, softRst = 1'b0, tickEn = 1'b0;
  logic        cmplSet, delaySet;
  logic [7:0]  liveCount, liveTimer;

  int errors = 0;
  int checks = 0;

  // bench reference state
  logic [7:0] mCount = 8'd1, mTimer = 8'd0;
  logic       mCmpl = 1'b0, mDly = 1'b0;

  always #5 clk = ~clk;

  irq_moderator dut_i (
    .clk(clk), .rst_n(rst_n), .ctrlValue(ctrlValue), .ctrlWr(ctrlWr),
    .frameDone(frameDone), .softRst(softRst), .tickEn(tickEn),
    .cmplSet(cmplSet), .delaySet(delaySet),
    .liveCount(liveCount), .liveTimer(liveTimer)
  );

  function automatic logic [17:0] refNext(input logic [31:0] cv, input logic wr,
      input logic done, input logic srst, input logic tick,
      input logic [7:0] c, input logic [7:0] t);
    logic [7:0] thr, dly, nc, nt;
    logic rearm, expire, hit, pc, pd;
    thr = cv[23:16];
    dly = cv[31:24];
    if (srst) return {8'd1, 8'd0, 1'b0, 1'b0};
    rearm  = done && dly != 0;
    expire = tick && t == 8'd1 && !rearm;
    hit    = done && c <= 8'd1;
    pc = hit && !wr;
    pd = expire;
    nc = c;
    if (wr || expire || hit) nc = thr;
    else if (done) nc = c - 8'd1;
    nt = t;
    if (rearm) nt = dly;
    else if (tick && t != 0) nt = t - 8'd1;
    return {nc, nt, pc, pd};
  endfunction

  task automatic compare(input string tag);
    checks++;
    if (liveCount !== mCount || liveTimer !== mTimer ||
        cmplSet !== mCmpl || delaySet !== mDly) begin
      errors++;
      $display("FAIL %s: got count=%0d timer=%0d cmpl=%0b dly=%0b, expected count=%0d timer=%0d cmpl=%0b dly=%0b",
               tag, liveCount, liveTimer, cmplSet, delaySet, mCount, mTimer, mCmpl, mDly);
    end
  endtask

  // called at a negedge: drive, advance model, wait one cycle, compare
  task automatic step(input logic [31:0] cv, input logic wr, input logic done,
      input logic srst, input logic tick, input string tag);
    logic [17:0] nx;
    ctrlValue = cv; ctrlWr = wr; frameDone = done; softRst = srst; tickEn = tick;
    nx = refNext(cv, wr, done, srst, tick, mCount, mTimer);
    {mCount, mTimer, mCmpl, mDly} = nx;
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 reset state");

    // R2/R3: threshold 3, no delay
    step(32'h0003_0000, 1, 0, 0, 0, "R8 write loads threshold");
    step(32'h0003_0000, 0, 1, 0, 0, "R2 decrement 3->2");
    step(32'h0003_0000, 0, 1, 0, 0, "R2 decrement 2->1");
    step(32'h0003_0000, 0, 1, 0, 0, "R3 count hit pulse and reload");
    step(32'h0003_0000, 0, 0, 0, 0, "R3 pulse lasts one cycle");

    // R4/R6: delay 5
    step(32'h0503_0000, 1, 0, 0, 0, "R8 write with delay");
    step(32'h0503_0000, 0, 1, 0, 0, "R4 completion arms timer");
    for (int i = 0; i < 4; i++) step(32'h0503_0000, 0, 0, 0, 1, "R6 tick decrement");
    step(32'h0503_0000, 0, 0, 0, 0, "R6 hold without tick");

    // R5/R7: zero delay keeps timer running
    step(32'h0003_0000, 1, 0, 0, 0, "R8 reload, timer kept");
    step(32'h0003_0000, 0, 1, 0, 0, "R5 zero delay leaves timer");
    step(32'h0003_0000, 0, 0, 0, 1, "R7 expiry pulse and reload");
    step(32'h0003_0000, 0, 0, 0, 1, "R7 no second pulse at zero");
    step(32'h0003_0000, 0, 0, 0, 1, "R6 stays at zero");

    // R8: write overrides a completion that would hit
    step(32'h0002_0000, 1, 0, 0, 0, "R8 write threshold 2");
    step(32'h0002_0000, 0, 1, 0, 0, "R2 decrement 2->1");
    step(32'h0002_0000, 1, 1, 0, 0, "R8 write beats completion");

    // R9: rearm beats expiry
    step(32'h0204_0000, 1, 0, 0, 0, "R8 write thr 4 delay 2");
    step(32'h0204_0000, 0, 1, 0, 0, "R4 arm timer 2");
    step(32'h0204_0000, 0, 0, 0, 1, "R6 timer 2->1");
    step(32'h0204_0000, 0, 1, 0, 1, "R9 rearm suppresses expiry");

    // R10: zero delay lets expiry happen with completion
    step(32'h0004_0000, 1, 0, 0, 1, "R6 timer 2->1 with write");
    step(32'h0004_0000, 0, 1, 0, 1, "R10 expiry with completion");

    // threshold 0 behaves as immediate hit
    step(32'h0000_0000, 1, 0, 0, 0, "R8 write threshold 0");
    step(32'h0000_0000, 0, 1, 0, 0, "R3 count 0 completion pulses");

    // R11
    step(32'h0905_0000, 1, 0, 0, 0, "R8 write thr 5 delay 9");
    step(32'h0905_0000, 0, 1, 0, 0, "R4 arm timer 9");
    step(32'h0905_0000, 1, 1, 1, 1, "R11 soft reset overrides all");

    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] cv;
      cv = {5'd0, 3'($urandom_range(0, 4)), 5'd0, 3'($urandom_range(0, 5)), 16'h0};
      if ($urandom_range(0, 9) == 0) cv[31:24] = 8'd1;
      step(cv, $urandom_range(0, 9) == 0, $urandom_range(0, 2) == 0,
           $urandom_range(0, 49) == 0, $urandom_range(0, 1) == 0,
           "R2 R3 R6 R7 random mix");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule